// File: doc/BRIEF.md
# Fan Stall and Drive-Fail Monitor

This block sits beside a closed-loop fan speed controller and watches the tachometer readings it produces. Each reading is a 13-bit period count, so a larger count means a slower fan. The block raises two kinds of fault.

The first fault is a stall. When a reading is slower than the valid-count threshold, the block pulses a stall output so that the controller starts a spin-up. When a spin-up attempt ends, the block checks the same threshold again and pulses a retry output if the fan is still too slow. It also tells the controller when the programmed target is slower than the stall threshold. In that case the controller holds the present drive setting and does not regulate to the target.

The second fault is a drive failure. The check is armed only while the controller is active and the upper byte of the drive word is all ones. The block counts consecutive readings that fall short of the target by more than a guard band. When that count reaches a programmable persistence length, the block sets a sticky status bit, and the interrupt follows that bit through an enable. The configuration values come from a register file outside the block. That register file supplies a reset default of F5h for the valid-count threshold and 00h for both fail-band bytes.

Top module: `fan_fault_monitor`

## Requirements
- R1: The stall threshold is {cfg_valid, 5'b11111}, so cfg_valid carries tach weights 4096 down to 32. In the cycle after a tach strobe whose reading is greater than this threshold, stall_pulse is high for exactly one cycle. A reading equal to the threshold gives no pulse.
- R2: No stall pulse is produced for a strobe that arrives while spinup_busy is high.
- R3: In the cycle after spinup_end, spin_retry is high if the reading is greater than the stall threshold. The reading used is the one strobed in that same cycle if there is one, and otherwise the last reading that was strobed. spin_retry is not affected by spinup_busy.
- R4: target_ignored is high, in the same cycle, exactly when cfg_target is greater than the stall threshold.
- R5: A drive-fail sample is a strobe that arrives while fsc_active is high and drive_word[15:8] equals FFh, and whose reading is greater than cfg_target + band. The sum is taken at 14 bits. The band is {cfg_band_hi, cfg_band_lo[7:3]}, and cfg_band_lo[2:0] is unused.
- R6: cfg_persist values 01, 10 and 11 need 16, 32 and 64 consecutive drive-fail samples. drive_fail is set in the cycle after the last of these samples. A strobe that does not qualify clears the count, and so does any cycle in which the check is disarmed.
- R7: With cfg_persist equal to 00, drive_fail is never set.
- R8: drive_fail is sticky. A fail_clr pulse clears it in the next cycle. If a qualifying sample would set it in the same cycle as a clear, the set wins. While the failure goes on, each further qualifying sample sets it again.
- R9: irq equals drive_fail ANDed with cfg_int_en.
- R10: After reset, stall_pulse, spin_retry, drive_fail and irq are low, and the stored reading is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 8 | Stall threshold, upper 8 bits of the count |
| cfg_band_lo | input | 8 | Fail band low byte, bits 7:3 used |
| cfg_band_hi | input | 8 | Fail band high byte |
| cfg_target | input | 13 | Target tach count |
| cfg_persist | input | 2 | Persistence select (00 disables the check) |
| cfg_int_en | input | 1 | Interrupt enable |
| drive_word | input | 16 | Current fan drive setting |
| fsc_active | input | 1 | Speed controller is running |
| tach_count | input | 13 | Latest tach period count |
| tach_valid | input | 1 | Strobe for tach_count |
| spinup_busy | input | 1 | A spin-up routine is running |
| spinup_end | input | 1 | A spin-up attempt ends this cycle |
| fail_clr | input | 1 | Clears the drive-fail status |
| stall_pulse | output | 1 | One-cycle request to start a spin-up |
| spin_retry | output | 1 | The spin-up attempt failed and a retry is needed |
| target_ignored | output | 1 | The target is slower than the stall threshold |
| drive_fail | output | 1 | Sticky drive-fail status |
| irq | output | 1 | Interrupt |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a status clear and a qualifying drive-fail sample. The bench provokes this by holding the fan short of its target until the persistence count is reached, then sending a qualifying reading together with fail_clr. The status bit must stay set. The second pair is the end of a spin-up and a new tach strobe. The bench pulses spinup_end with a reading that is on the opposite side of the threshold from the stored one. It checks that the retry decision follows the new reading, and, when spinup_busy is high, that the stall pulse stays low.

// File: rtl/fan_fault_monitor.sv
module fan_fault_monitor #(
  parameter int TW = 13,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    cfg_valid,
  input  logic [7:0]    cfg_band_lo,
  input  logic [7:0]    cfg_band_hi,
  input  logic [TW-1:0] cfg_target,
  input  logic [1:0]    cfg_persist,
  input  logic          cfg_int_en,
  input  logic [DW-1:0] drive_word,
  input  logic          fsc_active,
  input  logic [TW-1:0] tach_count,
  input  logic          tach_valid,
  input  logic          spinup_busy,
  input  logic          spinup_end,
  input  logic          fail_clr,
  output logic          stall_pulse,
  output logic          spin_retry,
  output logic          target_ignored,
  output logic          drive_fail,
  output logic          irq
);
  localparam int LOWB = TW - 8;
  localparam int CW   = 7;

  logic [TW-1:0] thr, band, last_count, eval_count;
  logic [TW:0]   limit;
  logic [CW-1:0] cnt, need;
  logic          armed, hit, qual, set_fail;

  // R1, R4: threshold fills unused low bits with ones
  assign thr            = {cfg_valid, {LOWB{1'b1}}};
  assign target_ignored = cfg_target > thr;

  // R5
  assign band  = {cfg_band_hi, cfg_band_lo[7 -: LOWB]};
  assign limit = {1'b0, cfg_target} + {1'b0, band};
  assign hit   = {1'b0, tach_count} > limit;
  assign armed = fsc_active && (&drive_word[DW-1:DW-8]) && (cfg_persist != 2'b00);
  assign qual  = armed && tach_valid && hit;

  // R6
  always_comb begin
    case (cfg_persist)
      2'b01:   need = CW'(16);
      2'b10:   need = CW'(32);
      2'b11:   need = CW'(64);
      default: need = '0;
    endcase
  end
  assign set_fail = qual && (cnt >= need - CW'(1));

  // R3: prefer a reading strobed in the same cycle
  assign eval_count = tach_valid ? tach_count : last_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_count  <= '0;
      stall_pulse <= 1'b0;
      spin_retry  <= 1'b0;
      cnt         <= '0;
      drive_fail  <= 1'b0;
    end else begin
      if (tach_valid) last_count <= tach_count;
      stall_pulse <= tach_valid && !spinup_busy && (tach_count > thr);  // R1, R2
      spin_retry  <= spinup_end && (eval_count > thr);                    // R3
      if (!armed || (tach_valid && !hit)) cnt <= '0;
      else if (qual && cnt < need)        cnt <= cnt + CW'(1);
      if (set_fail)      drive_fail <= 1'b1;                              // R8
      else if (fail_clr) drive_fail <= 1'b0;
    end
  end

  assign irq = drive_fail & cfg_int_en;                                   // R9
endmodule

module fan_fault_monitor_chk #(
  parameter int TW = 13,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    cfg_valid,
  input logic [1:0]    cfg_persist,
  input logic          cfg_int_en,
  input logic [DW-1:0] drive_word,
  input logic          fsc_active,
  input logic [TW-1:0] tach_count,
  input logic          tach_valid,
  input logic          spinup_busy,
  input logic          fail_clr,
  input logic          stall_pulse,
  input logic          drive_fail,
  input logic          irq
);
  assert_stall_after_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tach_valid && !spinup_busy && (tach_count[TW-1:TW-8] > cfg_valid) |=> stall_pulse);
  assert_stall_needs_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stall_pulse |-> $past(tach_valid));
  assert_busy_blocks_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spinup_busy |=> !stall_pulse);
  assert_fail_needs_arming_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_fail) |-> $past(fsc_active && (&drive_word[DW-1:DW-8])));
  assert_persist_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_persist == 2'b00) && !drive_fail |=> !drive_fail);
  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drive_fail && !fail_clr |=> drive_fail);
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> drive_fail && cfg_int_en);
endmodule

bind fan_fault_monitor fan_fault_monitor_chk #(.TW(TW), .DW(DW)) u_chk (.*);

// File: tb/fan_fault_monitor_tb.sv
module fan_fault_monitor_tb;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  cfg_valid = 8'hF5, cfg_band_lo = 0, cfg_band_hi = 0;
  logic [12:0] cfg_target = 0, tach_count = 0;
  logic [1:0]  cfg_persist = 0;
  logic        cfg_int_en = 0, fsc_active = 0, tach_valid = 0;
  logic        spinup_busy = 0, spinup_end = 0, fail_clr = 0;
  logic [15:0] drive_word = 0;
  logic        stall_pulse, spin_retry, target_ignored, drive_fail, irq;

  int errors = 0, checks = 0, cycles = 0;
  int m_cnt = 0;
  bit m_fail = 0;
  bit pend = 0;

  typedef struct packed { logic stall; logic retry; logic fail; } exp_t;
  exp_t exp_q[$];

  fan_fault_monitor u_dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic int thr_f();
    return {cfg_valid, 5'b11111};
  endfunction

  task automatic send(input int cnt, input bit busy = 0, input bit sp_end = 0, input bit clr = 0);
    exp_t e;
    int need;
    bit armed, q, set;
    need  = (cfg_persist == 1) ? 16 : (cfg_persist == 2) ? 32 : 64;
    armed = fsc_active && drive_word[15:8] == 8'hFF && cfg_persist != 0;
    q     = armed && (cnt > int'(cfg_target) + int'({cfg_band_hi, cfg_band_lo[7:3]}));
    set   = q && (m_cnt >= need - 1);
    if (q) begin if (m_cnt < need) m_cnt++; end else m_cnt = 0;
    m_fail  = set | (m_fail & !clr);
    e.stall = (cnt > thr_f()) && !busy;
    e.retry = sp_end && (cnt > thr_f());
    e.fail  = m_fail;
    @(negedge clk);
    tach_count = 13'(cnt); tach_valid = 1; spinup_busy = busy; spinup_end = sp_end; fail_clr = clr;
    exp_q.push_back(e);
    @(negedge clk);
    tach_valid = 0; spinup_busy = 0; spinup_end = 0; fail_clr = 0;
    @(negedge clk);
  endtask

  always @(posedge clk) pend <= tach_valid;

  always @(negedge clk) if (pend) begin
    exp_t e;
    e = exp_q.pop_front();
    chk("R1/R2 stall", stall_pulse, e.stall);
    chk("R3 retry", spin_retry, e.retry);
    chk("R6/R8 drive_fail", drive_fail, e.fail);
    chk("R9 irq", irq, e.fail & cfg_int_en);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 stall reset", stall_pulse, 0);
    chk("R10 retry reset", spin_retry, 0);
    chk("R10 fail reset", drive_fail, 0);
    chk("R10 irq reset", irq, 0);
    rst_n = 1;
    @(negedge clk);
    // R10: stored reading is zero, so a lone spin-up end gives no retry
    spinup_end = 1; @(negedge clk); spinup_end = 0;
    chk("R10 R3 stored zero", spin_retry, 0);

    // R1 boundary: threshold is 7871
    send(7871);
    send(7872);
    send(500);
    // R2
    send(8000, 1);
    // R3 with a same-cycle strobe on the opposite side of the stored value
    send(100, 1, 1);
    send(8000, 0, 1);
    send(7000, 1, 1);
    // R3 from the stored reading
    send(8100);
    @(negedge clk); spinup_end = 1; @(negedge clk); spinup_end = 0;
    chk("R3 stored slow", spin_retry, 1);
    @(negedge clk);
    chk("R3 one cycle", spin_retry, 0);

    // R4
    cfg_target = 7872; #1 chk("R4 above", target_ignored, 1);
    cfg_target = 7871; #1 chk("R4 equal", target_ignored, 0);
    cfg_valid = 8'h10; cfg_target = 13'd600; #1 chk("R4 new threshold", target_ignored, 1);
    cfg_valid = 8'hF5;

    // R5/R6: band = 32 + 5 = 37, limit 2037
    cfg_target = 2000; cfg_band_hi = 8'h01; cfg_band_lo = 8'h2F;
    cfg_persist = 2'b01; fsc_active = 1; drive_word = 16'hFF40; cfg_int_en = 1;
    for (int i = 0; i < 15; i++) send(2038);
    send(2037);                                  // R5 boundary clears the count
    for (int i = 0; i < 16; i++) send(2038);     // R6 16th sets
    // R8: clear alone
    @(negedge clk); fail_clr = 1; @(negedge clk); fail_clr = 0;
    m_fail = 0;
    chk("R8 clear", drive_fail, 0);
    chk("R9 irq cleared", irq, 0);
    // R8: a clear and a set in the same cycle, the set wins
    send(3000, 0, 0, 1);
    cfg_int_en = 0; #1 chk("R9 disabled", irq, 0);
    cfg_int_en = 1;
    @(negedge clk); fail_clr = 1; @(negedge clk); fail_clr = 0; m_fail = 0;

    // R5: disarmed drive never fails
    drive_word = 16'hFEFF;
    for (int i = 0; i < 20; i++) send(4000);
    chk("R5 disarmed", drive_fail, 0);
    drive_word = 16'hFF00; fsc_active = 0;
    for (int i = 0; i < 20; i++) send(4000);
    fsc_active = 1;

    // R7
    cfg_persist = 2'b00;
    for (int i = 0; i < 70; i++) send(4000);
    chk("R7 disabled", drive_fail, 0);

    // R6 at 32 and at 64
    cfg_persist = 2'b10;
    for (int i = 0; i < 32; i++) send(4000);
    @(negedge clk); fail_clr = 1; @(negedge clk); fail_clr = 0; m_fail = 0;
    send(100);
    cfg_persist = 2'b11;
    for (int i = 0; i < 64; i++) send(4000);
    chk("R6 64 set", drive_fail, 1);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule